// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 32-bit unsigned operands and a single carry-in, returning a 32-bit sum and a carry-out. It is purely combinational and is meant to sit inside a larger datapath wherever a wide addition has to settle within one cycle. There is no clock, no reset and no handshake.

The word is divided into carry-select stages whose widths grow by one bit from one stage to the next, starting at one bit at the least significant end. Every bit position computes two results side by side: one assuming that the stage's incoming carry is 0 and one assuming it is 1. Both speculative carry chains ripple across the stage at the same time as earlier stages are still resolving. When the stage's real carry arrives, it only has to steer a row of multiplexers. The longest path therefore grows with roughly the square root of the word width, not with the full width.

With the default 32-bit width the stages hold 1, 2, 3, 4, 5, 6 and 7 bits. A final 4-bit stage covers the remaining upper bits. The primary carry-in enters the lowest stage, and the carry-out is taken from the top stage.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input combination, the concatenation {carryOut, sumOut} equals the 33-bit value opA + opB + carryIn.
- R2: With opA and opB both 0xFFFFFFFF and carryIn 1, sumOut is 0xFFFFFFFF and carryOut is 1.
- R3: With opA and opB both zero, sumOut equals carryIn in bit 0 and is zero above it, and carryOut is 0.
- R4: With opA 0xFFFFFFFF, opB zero and carryIn 1, a carry propagates through every stage: sumOut is zero and carryOut is 1. With carryIn 0, sumOut is 0xFFFFFFFF and carryOut is 0.
- R5: A carry produced below any bit position k (opA = 2^k - 1, opB = 1, carryIn 0) arrives at bit k across every stage boundary, so sumOut = 2^k.
- R6: carryOut is 1 exactly when opA + opB + carryIn is at least 2^32.
- R7: For fixed operands, raising carryIn from 0 to 1 raises the 33-bit result {carryOut, sumOut} by exactly one. Inside each stage, the carry-1 result is the carry-0 result plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First unsigned operand |
| opB | input | 32 | Second unsigned operand |
| carryIn | input | 1 | Carry into the least significant stage |
| sumOut | output | 32 | Low 32 bits of the sum |
| carryOut | output | 1 | Carry out of the most significant stage |

## Verification
All-ones operands with carry-in set make every stage's carry-1 result the selected one. This exposes a wrong select polarity or a broken link between stages. A run of ones followed by a single added bit is tried at each position, so that a carry is launched just below every stage boundary and inside every stage. A fault that only affects one stage's width or base offset then shows up at exactly that position. Alternating bit patterns and pairs of vectors that differ only in carry-in separate the speculative chains from the selection logic. Random operands cover the general sum and carry-out.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Width of stage idx: widths grow by one per stage, the last one is clipped to what remains.
  function automatic int stageWidth(input int dataW, input int idx);
    int remaining = dataW;
    int w = 0;
    for (int k = 0; k <= idx; k++) begin
      w = (k + 1 < remaining) ? k + 1 : remaining;
      if (k < idx) remaining -= w;
    end
    return w;
  endfunction

  // Bit offset of the least significant bit of stage idx.
  function automatic int stageBase(input int dataW, input int idx);
    int base = 0;
    for (int k = 0; k < idx; k++) base += stageWidth(dataW, k);
    return base;
  endfunction

  // Number of stages needed to cover dataW bits.
  function automatic int stageCount(input int dataW);
    int remaining = dataW;
    int n = 0;
    while (remaining > 0) begin
      remaining -= stageWidth(dataW, n);
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/csel_bit_cell.sv
module csel_bit_cell (
  input  logic aBit,
  input  logic bBit,
  input  logic carry0In,
  input  logic carry1In,
  output logic sum0,
  output logic sum1,
  output logic carry0Out,
  output logic carry1Out
);

  // Two full adders over the same operand bits, one per speculative chain.
  always_comb begin
    sum0      = aBit ^ bBit ^ carry0In;
    carry0Out = (aBit & bBit) | (aBit & carry0In) | (bBit & carry0In);
    sum1      = aBit ^ bBit ^ carry1In;
    carry1Out = (aBit & bBit) | (aBit & carry1In) | (bBit & carry1In);
  end

  // The carry-1 chain never carries less than the carry-0 chain.
  always_comb begin
    if (!$isunknown({carry0In, carry1In, carry0Out, carry1Out}))
      if (carry0In && !carry1In) begin end
      else assert_chain_order_R7: assert (!carry0Out || carry1Out)
        else $error("carry-0 chain carries while carry-1 chain does not");
  end

endmodule

// File: rtl/csel_stage.sv
module csel_stage #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] aSlice,
  input  logic [WIDTH-1:0] bSlice,
  input  logic             stageCarryIn,
  output logic [WIDTH-1:0] sumSlice,
  output logic             stageCarryOut
);

  logic [WIDTH:0]   chain0;
  logic [WIDTH:0]   chain1;
  logic [WIDTH-1:0] spec0;
  logic [WIDTH-1:0] spec1;

  assign chain0[0] = 1'b0;
  assign chain1[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    csel_bit_cell u_cell (
      .aBit      (aSlice[i]),
      .bBit      (bSlice[i]),
      .carry0In  (chain0[i]),
      .carry1In  (chain1[i]),
      .sum0      (spec0[i]),
      .sum1      (spec1[i]),
      .carry0Out (chain0[i+1]),
      .carry1Out (chain1[i+1])
    );
  end

  // The real stage carry picks one of the two precomputed results.
  always_comb begin
    sumSlice      = stageCarryIn ? spec1 : spec0;
    stageCarryOut = stageCarryIn ? chain1[WIDTH] : chain0[WIDTH];
  end

  always_comb begin
    if (!$isunknown({chain0[WIDTH], chain1[WIDTH], spec0, spec1}))
      assert_spec_plus_one_R7: assert ({chain1[WIDTH], spec1} ==
                                       {chain0[WIDTH], spec0} + (WIDTH+1)'(1))
        else $error("stage carry-1 result is not carry-0 result plus one");
  end

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut
);
  import csel_pkg::*;

  localparam int NUM_STAGES = stageCount(DATA_W);

  logic [NUM_STAGES:0] stageCarry;

  assign stageCarry[0] = carryIn;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    localparam int SW = stageWidth(DATA_W, s);
    localparam int SB = stageBase(DATA_W, s);
    csel_stage #(.WIDTH(SW)) u_stage (
      .aSlice        (opA[SB +: SW]),
      .bSlice        (opB[SB +: SW]),
      .stageCarryIn  (stageCarry[s]),
      .sumSlice      (sumOut[SB +: SW]),
      .stageCarryOut (stageCarry[s+1])
    );
  end

  assign carryOut = stageCarry[NUM_STAGES];

  logic [DATA_W:0] refSum;
  always_comb refSum = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};

  always_comb begin
    if (!$isunknown({opA, opB, carryIn, sumOut, carryOut})) begin
      assert_sum_matches_R1: assert ({carryOut, sumOut} == refSum)
        else $error("adder result differs from arithmetic sum");
      assert_carry_out_R6: assert (carryOut == refSum[DATA_W])
        else $error("carry-out does not flag overflow of the word");
      assert_low_bit_R3: assert (sumOut[0] == (opA[0] ^ opB[0] ^ carryIn))
        else $error("least significant sum bit wrong");
      if (&opA && &opB && carryIn)
        assert_all_ones_R2: assert (&sumOut && carryOut)
          else $error("all-ones inputs with carry-in gave wrong result");
    end
  end

endmodule

// File: tb/tb_sqrt_csel_adder.sv
`timescale 1ns/1ps
module tb_sqrt_csel_adder;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [31:0] sumOut;
  logic        carryOut;
  int          testsRun = 0;
  int          testsFailed = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  sqrt_csel_adder dut (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  task automatic applyAndCheck(input logic [31:0] a, input logic [31:0] b,
                               input logic c, input logic [32:0] expected,
                               input string req);
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    #2;
    testsRun++;
    if ({carryOut, sumOut} !== expected) begin
      testsFailed++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h",
               req, a, b, c, {carryOut, sumOut}, expected);
    end
  endtask

  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic c);
    return {1'b0, a} + {1'b0, b} + {32'd0, c};
  endfunction

  task automatic test_idle_zero();   // R3: zero operands, no carry-in
    applyAndCheck(32'd0, 32'd0, 1'b0, 33'd0, "R3");
  endtask

  task automatic test_zero_with_carry();   // R3
    applyAndCheck(32'd0, 32'd0, 1'b1, 33'd1, "R3");
  endtask

  task automatic test_all_ones();   // R2
    applyAndCheck(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, {1'b1, 32'hFFFF_FFFF}, "R2");
    applyAndCheck(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, {1'b1, 32'hFFFF_FFFE}, "R1");
  endtask

  task automatic test_full_propagate();   // R4
    applyAndCheck(32'hFFFF_FFFF, 32'd0, 1'b1, {1'b1, 32'd0}, "R4");
    applyAndCheck(32'hFFFF_FFFF, 32'd0, 1'b0, {1'b0, 32'hFFFF_FFFF}, "R4");
    applyAndCheck(32'd0, 32'hFFFF_FFFF, 1'b1, {1'b1, 32'd0}, "R4");
  endtask

  task automatic test_carry_each_position();   // R5
    for (int k = 1; k < 32; k++) begin
      logic [31:0] run = (32'd1 << k) - 32'd1;
      applyAndCheck(run, 32'd1, 1'b0, {1'b0, 32'd1 << k}, "R5");
    end
    applyAndCheck(32'h7FFF_FFFF, 32'd0, 1'b1, {1'b0, 32'h8000_0000}, "R5");
  endtask

  task automatic test_overflow_edge();   // R6
    applyAndCheck(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, {1'b0, 32'hFFFF_FFFF}, "R6");
    applyAndCheck(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, {1'b1, 32'd0}, "R6");
    applyAndCheck(32'h8000_0000, 32'h8000_0000, 1'b0, {1'b1, 32'd0}, "R6");
  endtask

  task automatic test_alternating();   // R1
    applyAndCheck(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, model(32'hAAAA_AAAA, 32'h5555_5555, 1'b0), "R1");
    applyAndCheck(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, model(32'hAAAA_AAAA, 32'h5555_5555, 1'b1), "R1");
    applyAndCheck(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, model(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1), "R1");
    applyAndCheck(32'h5555_5555, 32'h5555_5555, 1'b0, model(32'h5555_5555, 32'h5555_5555, 1'b0), "R1");
  endtask

  task automatic test_cin_step();   // R7: carry-in 1 result is carry-in 0 result plus one
    logic [32:0] low;
    for (int n = 0; n < 40; n++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = (n % 2 == 0) ? ~a : $urandom;
      applyAndCheck(a, b, 1'b0, model(a, b, 1'b0), "R7");
      low = {carryOut, sumOut};
      applyAndCheck(a, b, 1'b1, low + 33'd1, "R7");
    end
  endtask

  task automatic test_random();   // R1, R6
    for (int n = 0; n < 500; n++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      logic        c = 1'($urandom);
      applyAndCheck(a, b, c, model(a, b, c), (n % 2 == 0) ? "R1" : "R6");
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    test_idle_zero();
    test_zero_with_carry();
    test_all_ones();
    test_full_propagate();
    test_carry_each_position();
    test_overflow_edge();
    test_alternating();
    test_cin_step();
    test_random();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule